// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block receives a serial bit stream that arrives with its own bit clock and a frame-sync strobe. The incoming bit clock, strobe and data pins pass through synchronizer stages into the system clock domain. Each falling edge of the bit clock is detected there and treated as one sampling point. A strobe seen at one falling edge arms the receiver, and data is then taken most significant bit first on the falling edges that follow. Bits collect in an internal shift register. Software cannot see this register.

When a word is complete it is copied into a holding register at host address 0, and a full flag is raised. A format input selects 16-bit words, or 8-bit words that land in the low byte. A framing-mode input selects one of two modes. In per-word mode every word needs its own strobe. In continuous mode a single strobe starts an unbroken sequence of words. The status register at host address 1 reports the full flag and a sticky overrun flag.

The bit clock may stop at any point, and the receiver simply waits. When the bit clock and strobe pins are tied low, the holding register serves as a plain read/write register for the host.

Top module: `frm_rx`

## Requirements
- R1: After reset, full_o and ovr_o are 0 and the holding register (address 0) and the status register (address 1) both read 0.
- R2: Data is sampled on falling edges of sclk_i, most significant bit first. A strobe seen high at one falling edge makes the next falling edge carry the first data bit.
- R3: With fmt_byte_i = 0, a word is 16 bits and the holding register receives all 16 bits.
- R4: With fmt_byte_i = 1, a word is 8 bits. It is placed in holding bits [7:0], and bits [15:8] read 0.
- R5: With each_sync_i = 1, a completed word ends reception. Bits clocked in afterwards without a new strobe complete no word.
- R6: With each_sync_i = 0, words follow one another with no gap after a single strobe, and no further strobe is needed.
- R7: Completing a word sets full_o. A host read of address 0 (host_re_i = 1) clears full_o, unless a word completes in the same cycle.
- R8: A word that completes while full_o is set still overwrites the holding register and sets ovr_o. ovr_o stays set until a host write to address 1 with data bit 1 set.
- R9: If sclk_i stops, partial word state is kept, and reception resumes correctly when edges return.
- R10: With sclk_i and sync_i held low, no word is ever received. The host can write address 0 and read the written value back.
- R11: Address 1 reads back full in bit 0 and overrun in bit 1, with the other bits 0.
- R12: A strobe arriving in the middle of a word discards the partial word and restarts reception at the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_byte_i | input | 1 | 1: 8-bit words, 0: 16-bit words |
| each_sync_i | input | 1 | 1: strobe per word, 0: continuous |
| sclk_i | input | 1 | External serial bit clock |
| sync_i | input | 1 | Receive frame-sync strobe |
| sdat_i | input | 1 | Serial data |
| host_addr_i | input | 1 | 0: holding register, 1: status |
| host_re_i | input | 1 | Host read strobe |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data (combinational) |
| full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is an overrun. It needs a second word to finish while the host has not yet read the first one. The bench therefore switches off its reading monitor, shifts in two framed words back to back, and then checks the flags, the holding contents and the status register. After that it clears the overrun through a status write. The continuous mode and the stopped-clock case are driven the same way, by shaping the bit clock directly. One sequence puts a long low gap in the middle of a word. Another sends three words after a single strobe, and a further one sends a strobe partway through a word.

// File: rtl/frm_rx_pkg.sv
package frm_rx_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    ADR_DATA = 1'b0,
    ADR_STAT = 1'b1
  } adr_e;

  localparam int unsigned STAT_FULL = 0;
  localparam int unsigned STAT_OVR  = 1;
endpackage

// File: rtl/frm_rx_edge.sv
module frm_rx_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sync_i,
  input  logic sdat_i,
  output logic fall_o,
  output logic sync_o,
  output logic dat_o
);
  // bit order in each stage: {sclk, sync, data}
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [2:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {sclk_i, sync_i, sdat_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= g_stg[s-1].q;
    end
  end

  logic [2:0] cur;
  logic       sclk_prev_q;

  assign cur = g_stg[STAGES-1].q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= cur[2];

  assign fall_o = sclk_prev_q & ~cur[2];
  assign sync_o = cur[1];
  assign dat_o  = cur[0];
endmodule

// File: rtl/frm_rx_shift.sv
module frm_rx_shift #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              sync_i,
  input  logic              dat_i,
  input  logic              fmt_byte_i,
  input  logic              each_sync_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] sr_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  last;
  logic [WORD_W-1:0] sr_nxt;

  assign last   = fmt_byte_i ? CNT_W'(BYTE_W - 1) : CNT_W'(WORD_W - 1);
  assign sr_nxt = {sr_q[WORD_W-2:0], dat_i};
  assign done_o = fall_i && busy_q && !sync_i && (cnt_q == last);
  assign word_o = sr_nxt;
  assign sr_o   = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else if (fall_i) begin
      if (sync_i) begin
        // strobe arms or restarts; first data bit on the next falling edge
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        sr_q <= sr_nxt;
        if (cnt_q == last) begin
          cnt_q  <= '0;
          busy_q <= !each_sync_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frm_rx_hold.sv
module frm_rx_hold
  import frm_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              fmt_byte_i,
  input  logic              addr_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic [WORD_W-1:0] hold_o
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] placed;
  logic              full_q, ovr_q;
  logic              rd_data, wr_data, ovr_clr;

  assign rd_data = re_i && (addr_i == ADR_DATA);
  assign wr_data = we_i && (addr_i == ADR_DATA);
  assign ovr_clr = we_i && (addr_i == ADR_STAT) && wdata_i[STAT_OVR];

  assign placed = fmt_byte_i ? {{(WORD_W-BYTE_W){1'b0}}, word_i[BYTE_W-1:0]} : word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (done_i)       hold_q <= placed;
      else if (wr_data) hold_q <= wdata_i;

      if (done_i)       full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;

      if (done_i && full_q && !rd_data) ovr_q <= 1'b1;
      else if (ovr_clr)                 ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_DATA) begin
      rdata_o = hold_q;
    end else begin
      rdata_o[STAT_FULL] = full_q;
      rdata_o[STAT_OVR]  = ovr_q;
    end
  end

  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/frm_rx.sv
module frm_rx
  import frm_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = frm_rx_pkg::WORD_W,
  parameter int unsigned BYTE_W      = frm_rx_pkg::BYTE_W,
  parameter int unsigned SYNC_STAGES = frm_rx_pkg::SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_byte_i,
  input  logic              each_sync_i,
  input  logic              sclk_i,
  input  logic              sync_i,
  input  logic              sdat_i,
  input  logic              host_addr_i,
  input  logic              host_re_i,
  input  logic              host_we_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic              fall_w, sync_w, dat_w, done_w;
  logic [WORD_W-1:0] word_w, sr_w, hold_w;

  frm_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sync_i (sync_i),
    .sdat_i (sdat_i),
    .fall_o (fall_w),
    .sync_o (sync_w),
    .dat_o  (dat_w)
  );

  frm_rx_shift #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall_w),
    .sync_i      (sync_w),
    .dat_i       (dat_w),
    .fmt_byte_i  (fmt_byte_i),
    .each_sync_i (each_sync_i),
    .done_o      (done_w),
    .word_o      (word_w),
    .sr_o        (sr_w)
  );

  frm_rx_hold #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_w),
    .word_i     (word_w),
    .fmt_byte_i (fmt_byte_i),
    .addr_i     (host_addr_i),
    .re_i       (host_re_i),
    .we_i       (host_we_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .full_o     (full_o),
    .ovr_o      (ovr_o),
    .hold_o     (hold_w)
  );
endmodule

// File: rtl/frm_rx_chk.sv
module frm_rx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fmt_byte_i,
  input logic              host_addr_i,
  input logic              host_re_i,
  input logic              host_we_i,
  input logic [WORD_W-1:0] host_wdata_i,
  input logic              full_o,
  input logic              ovr_o,
  input logic              fall,
  input logic              done,
  input logic [WORD_W-1:0] sr,
  input logic [WORD_W-1:0] hold
);
  assert_full_from_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(done));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && host_addr_i == 1'b0 && !done) |=> !full_o);

  assert_ovr_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(full_o && done));

  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !(host_we_i && host_addr_i == 1'b1 && host_wdata_i[1])) |=> ovr_o);

  assert_byte_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && fmt_byte_i) |=> (hold[WORD_W-1:BYTE_W] == '0));

  assert_stopped_clock_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(sr));
endmodule

bind frm_rx frm_rx_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fmt_byte_i   (fmt_byte_i),
  .host_addr_i  (host_addr_i),
  .host_re_i    (host_re_i),
  .host_we_i    (host_we_i),
  .host_wdata_i (host_wdata_i),
  .full_o       (full_o),
  .ovr_o        (ovr_o),
  .fall         (fall_w),
  .done         (done_w),
  .sr           (sr_w),
  .hold         (hold_w)
);

// File: tb/sim_frm_rx.sv
`timescale 1ns/1ps
module sim_frm_rx;
  localparam int H = 6;  // system cycles per half bit clock

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fmt_byte = 1'b0, each_sync = 1'b1;
  logic        sclk = 1'b0, sync = 1'b0, sdat = 1'b0;
  logic        m_addr = 1'b0, m_re = 1'b0, m_we = 1'b0;
  logic [15:0] m_wdata = '0;
  logic        mon_en = 1'b0, mon_act = 1'b0;
  logic        host_addr, host_re;
  logic [15:0] rdata;
  logic        full, ovr;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  assign host_addr = mon_act ? 1'b0 : m_addr;
  assign host_re   = mon_act | m_re;

  frm_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_byte_i(fmt_byte), .each_sync_i(each_sync),
    .sclk_i(sclk), .sync_i(sync), .sdat_i(sdat),
    .host_addr_i(host_addr), .host_re_i(host_re), .host_we_i(m_we),
    .host_wdata_i(m_wdata), .host_rdata_o(rdata), .full_o(full), .ovr_o(ovr)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b, logic s);
    sclk = 1'b1; sdat = b; sync = s;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send(logic [15:0] v, int n, logic with_sync, int pause_at);
    if (with_sync) sbit(1'b0, 1'b1);
    for (int i = n - 1; i >= 0; i--) begin
      if (i == pause_at) repeat (500) @(negedge clk);
      sbit(v[i], 1'b0);
    end
    sync = 1'b0;
  endtask

  task automatic expect_word(logic [15:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic host_write(logic a, logic [15:0] d);
    m_addr = a; m_wdata = d; m_we = 1'b1;
    @(negedge clk);
    m_we = 1'b0;
  endtask

  task automatic peek(logic a, output logic [15:0] d);
    m_addr = a;
    #1 d = rdata;
  endtask

  task automatic host_read0(output logic [15:0] d);
    m_addr = 1'b0; m_re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    m_re = 1'b0;
  endtask

  // monitor: pops expected words as the design reports them
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && full) begin
        mon_act = 1'b1;
        #1;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7: unexpected word actual %h expected none", rdata);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
        @(negedge clk);
        mon_act = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 full", {15'd0, full}, 16'd0);
    check("R1 ovr", {15'd0, ovr}, 16'd0);
    peek(1'b0, d); check("R1 hold", d, 16'h0000);
    peek(1'b1, d); check("R1 status", d, 16'h0000);

    mon_en = 1'b1;
    // R2 R3 per-word 16-bit words
    fmt_byte = 1'b0; each_sync = 1'b1;
    expect_word(16'hA5C3, "R2 msb first");   send(16'hA5C3, 16, 1'b1, -1);
    repeat (20) @(negedge clk);
    expect_word(16'h8001, "R3 word edges");  send(16'h8001, 16, 1'b1, -1);
    repeat (20) @(negedge clk);
    expect_word(16'h1234, "R3 word");        send(16'h1234, 16, 1'b1, -1);
    repeat (20) @(negedge clk);

    // R5 bits without a strobe are ignored
    send(16'hFFFF, 16, 1'b0, -1);
    repeat (20) @(negedge clk);
    check("R5 no word full", {15'd0, full}, 16'd0);
    check("R5 no word queue", 16'(exp_q.size()), 16'd0);
    peek(1'b0, d); check("R5 hold unchanged", d, 16'h1234);

    // R4 byte mode
    fmt_byte = 1'b1;
    expect_word(16'h005A, "R4 byte");        send(16'h005A, 8, 1'b1, -1);
    repeat (20) @(negedge clk);
    expect_word(16'h00C7, "R4 byte high bits dropped"); send(16'h00C7, 8, 1'b1, -1);
    repeat (20) @(negedge clk);

    // R6 continuous mode: one strobe, three words
    fmt_byte = 1'b0; each_sync = 1'b0;
    expect_word(16'h0F0F, "R6 cont w0");
    expect_word(16'hF00D, "R6 cont w1");
    expect_word(16'h3C5A, "R6 cont w2");
    send(16'h0F0F, 16, 1'b1, -1);
    send(16'hF00D, 16, 1'b0, -1);
    send(16'h3C5A, 16, 1'b0, -1);
    repeat (20) @(negedge clk);
    check("R6 queue drained", 16'(exp_q.size()), 16'd0);

    // R12 strobe mid-word restarts
    each_sync = 1'b1;
    send(16'h00FF, 5, 1'b1, -1);
    expect_word(16'h6B2E, "R12 restart");    send(16'h6B2E, 16, 1'b1, -1);
    repeat (20) @(negedge clk);

    // R9 stopped bit clock mid-word
    expect_word(16'hD00B, "R9 pause");       send(16'hD00B, 16, 1'b1, 7);
    repeat (20) @(negedge clk);
    check("R9 queue drained", 16'(exp_q.size()), 16'd0);

    // R8 R11 overrun with the monitor off
    mon_en = 1'b0;
    send(16'h1111, 16, 1'b1, -1);
    send(16'h2222, 16, 1'b1, -1);
    repeat (20) @(negedge clk);
    check("R8 full", {15'd0, full}, 16'd1);
    check("R8 ovr", {15'd0, ovr}, 16'd1);
    peek(1'b1, d); check("R11 status both", d, 16'h0003);
    peek(1'b0, d); check("R8 overwritten", d, 16'h2222);
    host_write(1'b1, 16'h0001);
    check("R8 no clear without bit1", {15'd0, ovr}, 16'd1);
    host_write(1'b1, 16'h0002);
    check("R8 cleared", {15'd0, ovr}, 16'd0);
    peek(1'b1, d); check("R11 status full only", d, 16'h0001);
    host_read0(d); check("R7 read data", d, 16'h2222);
    check("R7 cleared", {15'd0, full}, 16'd0);

    // R10 pins tied low, holding register is general purpose
    sclk = 1'b0; sync = 1'b0;
    host_write(1'b0, 16'hBEEF);
    for (int i = 0; i < 40; i++) begin
      sdat = ~sdat;
      repeat (5) @(negedge clk);
    end
    check("R10 no reception", {15'd0, full}, 16'd0);
    peek(1'b0, d); check("R10 readback", d, 16'hBEEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule